// File: doc/BRIEF.md
# Performance Monitor Counter Bank

This block holds four 32-bit event counters for processor performance monitoring. Every clock, each counter looks at its own select code, picks one event from a shared set of per-cycle event inputs, and adds that event's occurrence count for the cycle. The counters can take 1 for every clock cycle, a multi-bit count of completed or dispatched instructions, a group of implementation-specific event counts, or rising edges of one selectable bit of a 32-bit time-base word. Codes 0 through 4 mean the same thing on all four counters. The select fields differ in width: 7, 6, 5 and 5 bits.

Software loads a counter through a single write strobe with an index and a data word. It reads a counter combinationally through a read index. The event inputs carry a new sample every clock and have no flow control. They are therefore plain per-cycle pins and not valid/ready streams, and there is no back-pressure anywhere in the block. The select fields and the time-base tap selector are static control pins, sampled every cycle.

Top module: `pmc_bank`

## Requirements
- R1: While `rst_n` is low, all four counters are cleared to zero. They read back as zero after reset is released, until the first increment or write.
- R2: Select code 0 holds the counter at its current value.
- R3: Select code 1 adds exactly 1 to the counter on every clock.
- R4: Select code 2 adds the value on `cmpl_cnt` (0 to 3) to the counter each clock.
- R5: Select code 4 adds the value on `disp_cnt` (0, 1 or 2) to the counter each clock.
- R6: Select code 3 adds 1 in each cycle where the chosen time-base bit is 1 and was 0 in the previous cycle. `tb_sel` chooses the bit of `tbl`, with the index counted from the least significant bit as 0: `tb_sel` 00 chooses `tbl[0]`, 01 chooses `tbl[8]`, 10 chooses `tbl[12]` and 11 chooses `tbl[16]`. In most-significant-first numbering these are bits 31, 23, 19 and 15.
- R7: A change of `tb_sel` never produces an edge by itself: the new bit is compared with that same bit's value in the previous cycle. The first cycle after reset release never counts an edge.
- R8: Select code 5+k, for k from 0 to 3, adds the 3-bit value in `impl_evt[3k+2:3k]` to the counter each clock.
- R9: Every select code above 8 is undefined and holds the counter. This applies to the full field width: up to 127 for counter 0 (`sel0`, 7 bits), up to 63 for counter 1 (`sel1`, 6 bits), and up to 31 for counters 2 and 3 (`sel2`, `sel3`, 5 bits).
- R10: When `wr_en` is high, counter `wr_idx` takes `wr_data` at the clock edge and that cycle's increment is discarded. `rd_data` always shows counter `rd_idx` combinationally.
- R11: Counters wrap modulo 2^32: incrementing 0xFFFFFFFF by n gives n-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpl_cnt | input | 2 | Instructions completed this cycle |
| disp_cnt | input | 2 | Instructions dispatched this cycle (0 to 2) |
| impl_evt | input | 12 | Four 3-bit implementation-specific event counts |
| tbl | input | 32 | Time-base lower word |
| tb_sel | input | 2 | Time-base tap selector |
| sel0 | input | 7 | Event select for counter 0 |
| sel1 | input | 6 | Event select for counter 1 |
| sel2 | input | 5 | Event select for counter 2 |
| sel3 | input | 5 | Event select for counter 3 |
| wr_en | input | 1 | Counter write strobe |
| wr_idx | input | 2 | Counter to write |
| wr_data | input | 32 | Value to write |
| rd_idx | input | 2 | Counter to read |
| rd_data | output | 32 | Value of counter `rd_idx` |

## Verification
The assertions check four rules on every cycle. A counter on code 0, or on an undefined code, holds when no write hits it. A counter on code 1 steps by exactly one. A write always lands its data and overrides the increment. The tap logic never reports an edge on a bit that currently reads 0. The bench's reference model covers the behaviour that depends on input history: edge counting across tap switches and the first cycle after reset, multi-occurrence sums from instruction and implementation inputs, wrap at 2^32, and agreement of all four counters over long random runs with mixed select codes.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int NCTR      = 4;
  localparam int SEL_MAX_W = 7;
  localparam int NTAP      = 4;

  localparam int CODE_HOLD   = 0;
  localparam int CODE_CYCLE  = 1;
  localparam int CODE_CMPL   = 2;
  localparam int CODE_TBEDGE = 3;
  localparam int CODE_DISP   = 4;
  localparam int CODE_IMPL0  = 5;

  // width of the select field of counter i
  function automatic int sel_width(input int i);
    if (i == 0) return 7;
    else if (i == 1) return 6;
    else return 5;
  endfunction

  // LSB-zero index of the time-base tap chosen by selector value k
  function automatic int tap_pos(input int k);
    case (k)
      0: return 0;
      1: return 8;
      2: return 12;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/pmc_tb_edge.sv
module pmc_tb_edge
  import pmc_pkg::*;
#(
  parameter int TB_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TB_W-1:0] tbl_i,
  input  logic [1:0]      tap_sel_i,
  output logic            edge_o
);
  logic [NTAP-1:0] tap_now;
  logic [NTAP-1:0] tap_prev;
  logic            prev_vld;
  logic [NTAP-1:0] tap_rise;

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    localparam int POS = tap_pos(k);
    assign tap_now[k]  = tbl_i[POS];
    assign tap_rise[k] = prev_vld & tap_now[k] & ~tap_prev[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tap_prev <= '0;
      prev_vld <= 1'b0;
    end else begin
      tap_prev <= tap_now;
      prev_vld <= 1'b1;
    end
  end

  assign edge_o = tap_rise[tap_sel_i];

  // R6
  edge_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |-> tbl_i[tap_pos(int'(tap_sel_i))]);
endmodule

// File: rtl/pmc_evt_mux.sv
module pmc_evt_mux
  import pmc_pkg::*;
#(
  parameter int SEL_W = 5,
  parameter int NIMPL = 4,
  parameter int EV_W  = 3
) (
  input  logic [SEL_W-1:0]      sel_i,
  input  logic [1:0]            cmpl_i,
  input  logic [1:0]            disp_i,
  input  logic                  tb_edge_i,
  input  logic [NIMPL*EV_W-1:0] impl_i,
  output logic [EV_W-1:0]       inc_o
);
  always_comb begin
    inc_o = '0;
    if (sel_i == SEL_W'(CODE_CYCLE))       inc_o = EV_W'(1);
    else if (sel_i == SEL_W'(CODE_CMPL))   inc_o = {{(EV_W-2){1'b0}}, cmpl_i};
    else if (sel_i == SEL_W'(CODE_TBEDGE)) inc_o = {{(EV_W-1){1'b0}}, tb_edge_i};
    else if (sel_i == SEL_W'(CODE_DISP))   inc_o = {{(EV_W-2){1'b0}}, disp_i};
    else begin
      for (int k = 0; k < NIMPL; k++) begin
        if (sel_i == SEL_W'(CODE_IMPL0 + k)) inc_o = impl_i[k*EV_W +: EV_W];
      end
    end
  end
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int CNT_W = 32,
  parameter int EV_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EV_W-1:0]  inc_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q_o <= '0;
    else if (wr_i) q_o <= wdata_i;
    else           q_o <= q_o + {{(CNT_W-EV_W){1'b0}}, inc_i};
  end

  // R10
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> q_o == $past(wdata_i));
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int TB_W  = 32,
  parameter int NIMPL = 4,
  parameter int EV_W  = 3,
  localparam int IDX_W = $clog2(NCTR)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            cmpl_cnt,
  input  logic [1:0]            disp_cnt,
  input  logic [NIMPL*EV_W-1:0] impl_evt,
  input  logic [TB_W-1:0]       tbl,
  input  logic [1:0]            tb_sel,
  input  logic [6:0]            sel0,
  input  logic [5:0]            sel1,
  input  logic [4:0]            sel2,
  input  logic [4:0]            sel3,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [CNT_W-1:0]      wr_data,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [CNT_W-1:0]      rd_data
);
  logic [SEL_MAX_W-1:0] sel_all [NCTR];
  logic [CNT_W-1:0]     cnt     [NCTR];
  logic                 tb_edge;

  assign sel_all[0] = sel0;
  assign sel_all[1] = {1'b0, sel1};
  assign sel_all[2] = {2'b0, sel2};
  assign sel_all[3] = {2'b0, sel3};

  pmc_tb_edge #(.TB_W(TB_W)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .tbl_i     (tbl),
    .tap_sel_i (tb_sel),
    .edge_o    (tb_edge)
  );

  for (genvar i = 0; i < NCTR; i++) begin : g_ctr
    localparam int SW = sel_width(i);
    logic [EV_W-1:0] inc;
    logic            hit;

    assign hit = wr_en && (wr_idx == IDX_W'(i));

    pmc_evt_mux #(.SEL_W(SW), .NIMPL(NIMPL), .EV_W(EV_W)) u_mux (
      .sel_i     (sel_all[i][SW-1:0]),
      .cmpl_i    (cmpl_cnt),
      .disp_i    (disp_cnt),
      .tb_edge_i (tb_edge),
      .impl_i    (impl_evt),
      .inc_o     (inc)
    );

    pmc_counter #(.CNT_W(CNT_W), .EV_W(EV_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (inc),
      .wr_i    (hit),
      .wdata_i (wr_data),
      .q_o     (cnt[i])
    );

    // R2
    hold_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_all[i] == SEL_MAX_W'(CODE_HOLD) && !hit) |=> $stable(cnt[i]));

    // R3
    cycle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_all[i] == SEL_MAX_W'(CODE_CYCLE) && !hit) |=> cnt[i] == $past(cnt[i]) + CNT_W'(1));

    // R9
    undef_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_all[i] >= SEL_MAX_W'(CODE_IMPL0 + NIMPL) && !hit) |=> $stable(cnt[i]));
  end

  assign rd_data = cnt[rd_idx];
endmodule

// File: tb/test_pmc_bank.sv
`timescale 1ns/1ps
module test_pmc_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmpl_cnt = '0, disp_cnt = '0, tb_sel = '0;
  logic [11:0] impl_evt = '0;
  logic [31:0] tbl = '0, wr_data = '0;
  logic [6:0]  sel0 = '0;
  logic [5:0]  sel1 = '0;
  logic [4:0]  sel2 = '0, sel3 = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = '0, rd_idx = '0;
  logic [31:0] rd_data;

  int checks = 0, fails = 0;
  bit [31:0] m_cnt [4];
  bit [3:0]  m_prev;
  bit        m_vld;
  string     m_tag [4];

  always #5 clk = ~clk;

  pmc_bank i_pmc_bank (
    .clk(clk), .rst_n(rst_n), .cmpl_cnt(cmpl_cnt), .disp_cnt(disp_cnt),
    .impl_evt(impl_evt), .tbl(tbl), .tb_sel(tb_sel),
    .sel0(sel0), .sel1(sel1), .sel2(sel2), .sel3(sel3),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  function automatic int tap(input int k);
    return (k == 0) ? 0 : (k == 1) ? 8 : (k == 2) ? 12 : 16;
  endfunction

  function automatic int code_of(input int i);
    return (i == 0) ? int'(sel0) : (i == 1) ? int'(sel1) : (i == 2) ? int'(sel2) : int'(sel3);
  endfunction

  function automatic string tag_of(input int c);
    case (c)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R6"; 4: return "R5";
      5, 6, 7, 8: return "R8";
      default: return "R9";
    endcase
  endfunction

  // advance the reference model by one clock using the inputs now driven
  task automatic model_step();
    bit e;
    bit [3:0] cur;
    for (int k = 0; k < 4; k++) cur[k] = tbl[tap(k)];
    e = m_vld && cur[tb_sel] && !m_prev[tb_sel];
    for (int i = 0; i < 4; i++) begin
      int c = code_of(i);
      int add = 0;
      if (!rst_n) begin m_cnt[i] = 0; m_tag[i] = "R1"; continue; end
      case (c)
        1: add = 1;
        2: add = cmpl_cnt;
        3: add = e;
        4: add = disp_cnt;
        5, 6, 7, 8: add = impl_evt[(c-5)*3 +: 3];
        default: add = 0;
      endcase
      if (wr_en && wr_idx == 2'(i)) begin m_cnt[i] = wr_data; m_tag[i] = "R10"; end
      else begin
        if (m_cnt[i] > 32'hFFFF_FFF8 && add > 0) m_tag[i] = "R11";
        else m_tag[i] = tag_of(c);
        m_cnt[i] = m_cnt[i] + 32'(add);
      end
    end
    if (!rst_n) begin m_prev = '0; m_vld = 1'b0; end
    else begin m_prev = cur; m_vld = 1'b1; end
  endtask

  task automatic compare();
    for (int i = 0; i < 4; i++) begin
      rd_idx = 2'(i);
      #1;
      checks++;
      if (rd_data !== m_cnt[i]) begin
        fails++;
        $display("FAIL %s counter %0d actual %h expected %h", m_tag[i], i, rd_data, m_cnt[i]);
      end
    end
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    compare();
  endtask

  task automatic set_all(input int c);
    sel0 = 7'(c); sel1 = 6'(c); sel2 = 5'(c); sel3 = 5'(c);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    set_all(1);
    tbl = '1;
    // R1: counters zero during and after reset
    repeat (3) cycle();
    rst_n = 1'b1;
    tbl = '1;
    set_all(3); // R7: bits already high at first cycle: no edge
    cycle();
    cycle();
    // R3 cycles
    set_all(1);
    repeat (10) cycle();
    // R2 hold
    set_all(0);
    cmpl_cnt = 3; disp_cnt = 2; impl_evt = '1;
    repeat (5) cycle();
    // R4 completed counts
    set_all(2);
    for (int v = 0; v < 4; v++) begin cmpl_cnt = 2'(v); cycle(); end
    // R5 dispatched counts
    set_all(4);
    for (int v = 0; v < 3; v++) begin disp_cnt = 2'(v); cycle(); cycle(); end
    // R8 implementation events
    for (int k = 0; k < 4; k++) begin
      set_all(5 + k);
      impl_evt = 12'h000 | (12'(k + 4) << (3 * k));
      cycle();
      impl_evt = 12'hFFF;
      cycle();
    end
    // R9 undefined codes, full width
    sel0 = 7'd127; sel1 = 6'd63; sel2 = 5'd31; sel3 = 5'd9;
    repeat (3) cycle();
    sel0 = 7'd69; sel1 = 6'd37; sel2 = 5'd20; sel3 = 5'd31;
    repeat (3) cycle();
    // R6 edges on every tap
    set_all(3);
    for (int t = 0; t < 4; t++) begin
      tb_sel = 2'(t);
      tbl = '0; cycle();
      tbl[tap(t)] = 1'b1; cycle();
      cycle();
      tbl = '0; cycle();
      tbl = 32'hFFFF_FFFF ^ (32'h1 << tap(t)); cycle();
    end
    // R7 switching taps with differing levels
    tbl = 32'h0000_0100; tb_sel = 2'd0; cycle(); cycle();
    tb_sel = 2'd1; cycle();
    tbl = 32'h0000_0101; tb_sel = 2'd0; cycle();
    tb_sel = 2'd2; tbl = 32'h0000_1000; cycle();
    tb_sel = 2'd3; cycle();
    // R10 write collides with increment
    set_all(1);
    for (int i = 0; i < 4; i++) begin
      wr_en = 1'b1; wr_idx = 2'(i); wr_data = 32'hA5A5_0000 + 32'(i);
      cycle();
    end
    // R11 wrap
    for (int i = 0; i < 4; i++) begin
      wr_en = 1'b1; wr_idx = 2'(i); wr_data = 32'hFFFF_FFFE;
      cycle();
    end
    repeat (3) cycle();
    sel2 = 5'd7; impl_evt = 12'hFFF;
    wr_en = 1'b1; wr_idx = 2'd2; wr_data = 32'hFFFF_FFFD; cycle();
    cycle();
    // random mix
    for (int n = 0; n < 3000; n++) begin
      sel0 = 7'($urandom_range(0, 12)); if ($urandom_range(0, 7) == 0) sel0 = 7'($urandom);
      sel1 = 6'($urandom_range(0, 10));
      sel2 = 5'($urandom_range(0, 9));
      sel3 = 5'($urandom);
      cmpl_cnt = 2'($urandom); disp_cnt = 2'($urandom_range(0, 2));
      impl_evt = 12'($urandom);
      if ($urandom_range(0, 3) == 0) tbl = $urandom;
      if ($urandom_range(0, 9) == 0) tb_sel = 2'($urandom);
      wr_en = ($urandom_range(0, 15) == 0);
      wr_idx = 2'($urandom);
      wr_data = ($urandom_range(0, 1) == 0) ? 32'hFFFF_FFF0 + 32'($urandom_range(0, 15)) : $urandom;
      cycle();
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule